// File: doc/BRIEF.md
# Fan Tachometer Period Monitor

This block measures the rotation period of four fans. Each tachometer line is brought into the clock domain and watched for rising edges. Between two edges a per-channel counter adds up the cycles on which a slow reference tick (nominally 90 kHz, so about 11.111 µs per count) is enabled. At each edge the total is stored as that fan's 16-bit result. Fan speed in RPM is 5,400,000 divided by the result; the block leaves that division to software. A fan that stops yields a saturated result of 0xFFFF.

The host reaches the results through a two-location byte window. A write to location 0 selects a register index, and a read from location 1 returns that register. Four temperature bytes come from outside the block and are readable through the same window. A 16-bit fan result is read as a low byte and then a high byte. The low-byte read captures the matching high byte into a per-channel shadow, so the pair always comes from one sample even if a new measurement lands between the two reads.

Top module: `fan_tach_monitor`

## Requirements
- R1: A host write with `host_sel`=0 loads `host_wdata` into the index register. A host read returns its byte on `host_rdata` on the clock edge that samples `host_rd`, and `host_rdata` holds that value until the next read. A read with `host_sel`=0 returns the index itself.
- R2: A read with `host_sel`=1 at index 0x25, 0x26, 0x27 or 0x80 returns temperature byte 0, 1, 2 or 3, which is bits [8t+7:8t] of `temp_in`.
- R3: For fan k (k = 0..3) the low byte of the result is at index 0x28+2k and the high byte at 0x29+2k. The result is the number of clock cycles with `tick_en`=1 in the window between two successive synchronised rising edges of `tach_in[k]`, counting the cycle that contains the closing edge.
- R4: The first rising edge after a stall restarts the count. The interval that follows gives a correct result again.
- R5: If a channel's running count reaches 0xFFFF without an edge, it stays there and the result becomes 0xFFFF.
- R6: Reading a fan's low byte captures that fan's high byte. A later high-byte read of the same fan returns the captured byte, even if the result has since changed.
- R7: A read with `host_sel`=1 at any index that is neither a temperature nor a fan byte returns 0x00.
- R8: A write with `host_sel`=1 changes neither the index nor any readable value.
- R9: After reset, `host_rdata`, the index, all counts, all results and all shadows are zero.
- R10: Counts advance only on cycles with `tick_en`=1. When `tick_en` stays low, each window yields a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Reference tick enable, one cycle per count |
| tach_in | input | 4 | Tachometer pulse lines, one per fan, asynchronous |
| temp_in | input | 32 | Four temperature bytes, byte t at bits [8t+7:8t] |
| host_sel | input | 1 | Window location: 0 = index, 1 = data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |

## Verification
The hardest case to reach is a high-byte change that lands between the two halves of a read. To produce it, the bench reads the low byte of a channel running with a period of 0x01F0 cycles. It then switches the channel's pulse period to 0x0210 and idles for several periods before reading the high byte, so the expected shadow value 0x01 differs from the live value 0x02. The stall case needs more than 65,535 ticks on a channel that never pulses. The bench leaves one channel silent from reset and only reads it once the cycle count is well past that limit. It then starts pulses on that channel to show recovery.

// File: rtl/fan_mon_pkg.sv
package fan_mon_pkg;

  localparam int NUM_FANS    = 4;
  localparam int NUM_TEMPS   = 4;
  localparam int CNT_W       = 16;
  localparam int SYNC_STAGES = 2;
  localparam int BYTE_W      = 8;

  // Index of the low byte of fan 0; fan k uses base+2k (low) and base+2k+1 (high)
  localparam logic [BYTE_W-1:0] FAN_BASE_IDX = 8'h28;

  // Temperature byte indices, element t serves temperature byte t
  localparam logic [NUM_TEMPS-1:0][BYTE_W-1:0] TEMP_IDX = {8'h80, 8'h27, 8'h26, 8'h25};

  function automatic logic [BYTE_W-1:0] fan_lo_idx(input int k);
    return FAN_BASE_IDX + BYTE_W'(2 * k);
  endfunction

  function automatic logic [BYTE_W-1:0] fan_hi_idx(input int k);
    return FAN_BASE_IDX + BYTE_W'(2 * k + 1);
  endfunction

endpackage

// File: rtl/fan_tach_sync.sv
module fan_tach_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_async,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], tach_async};
    prev_d = sync_q[STAGES-1];
    rise   = sync_q[STAGES-1] & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/fan_period_counter.sv
module fan_period_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             edge_seen,
  output logic [CNT_W-1:0] run_cnt,
  output logic [CNT_W-1:0] result
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] run_q, run_d;
  logic [CNT_W-1:0] res_q, res_d;
  logic [CNT_W-1:0] cnt_inc;
  logic             adv;

  always_comb begin
    adv     = tick_en && (run_q != CNT_MAX);
    cnt_inc = adv ? run_q + 1'b1 : run_q;
    run_d   = cnt_inc;
    res_d   = res_q;
    if (edge_seen) begin
      // closing edge: store the window total including this cycle's tick
      res_d = cnt_inc;
      run_d = '0;
    end else if (adv && (cnt_inc == CNT_MAX)) begin
      // stall: count just saturated without an edge
      res_d = CNT_MAX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      res_q <= '0;
    end else begin
      run_q <= run_d;
      res_q <= res_d;
    end
  end

  assign run_cnt = run_q;
  assign result  = res_q;

endmodule

// File: rtl/fan_reg_window.sv
module fan_reg_window
  import fan_mon_pkg::*;
#(
  parameter int NF = NUM_FANS,
  parameter int NT = NUM_TEMPS,
  parameter int CW = CNT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NF-1:0][CW-1:0]     fan_result,
  input  logic [NT*BYTE_W-1:0]      temp_in,
  input  logic                      host_sel,
  input  logic                      host_wr,
  input  logic                      host_rd,
  input  logic [BYTE_W-1:0]         host_wdata,
  output logic [BYTE_W-1:0]         host_rdata,
  output logic [BYTE_W-1:0]         index_out
);

  logic [BYTE_W-1:0]         index_q, index_d;
  logic [BYTE_W-1:0]         rdata_q, rdata_d;
  logic [NF-1:0][BYTE_W-1:0] shadow_q, shadow_d;
  logic [BYTE_W-1:0]         rd_val;
  logic                      data_rd;

  always_comb begin
    data_rd = host_rd && host_sel;
    index_d = index_q;
    if (host_wr && !host_sel) begin
      index_d = host_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (!host_sel) begin
      rd_val = index_q;
    end else begin
      for (int t = 0; t < NT; t++) begin
        if (index_q == TEMP_IDX[t]) begin
          rd_val = temp_in[t*BYTE_W +: BYTE_W];
        end
      end
      for (int k = 0; k < NF; k++) begin
        if (index_q == fan_lo_idx(k)) begin
          rd_val = fan_result[k][BYTE_W-1:0];
        end
        if (index_q == fan_hi_idx(k)) begin
          rd_val = shadow_q[k];
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NF; k++) begin
      shadow_d[k] = shadow_q[k];
      if (data_rd && (index_q == fan_lo_idx(k))) begin
        shadow_d[k] = fan_result[k][CW-1:BYTE_W];
      end
    end
    rdata_d = host_rd ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q  <= '0;
      rdata_q  <= '0;
      shadow_q <= '0;
    end else begin
      index_q  <= index_d;
      rdata_q  <= rdata_d;
      shadow_q <= shadow_d;
    end
  end

  assign host_rdata = rdata_q;
  assign index_out  = index_q;

endmodule

// File: rtl/fan_tach_monitor.sv
module fan_tach_monitor
  import fan_mon_pkg::*;
#(
  parameter int NF = NUM_FANS,
  parameter int NT = NUM_TEMPS,
  parameter int CW = CNT_W,
  parameter int SS = SYNC_STAGES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [NF-1:0]        tach_in,
  input  logic [NT*BYTE_W-1:0] temp_in,
  input  logic                 host_sel,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [BYTE_W-1:0]    host_wdata,
  output logic [BYTE_W-1:0]    host_rdata
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_sync_q[1];

  logic [NF-1:0]          tach_rise;
  logic [NF-1:0][CW-1:0]  fan_run;
  logic [NF-1:0][CW-1:0]  fan_result;
  logic [BYTE_W-1:0]      index_q;

  for (genvar g = 0; g < NF; g++) begin : g_chan
    fan_tach_sync #(.STAGES(SS)) u_sync (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .tach_async (tach_in[g]),
      .rise       (tach_rise[g])
    );

    fan_period_counter #(.CNT_W(CW)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .tick_en   (tick_en),
      .edge_seen (tach_rise[g]),
      .run_cnt   (fan_run[g]),
      .result    (fan_result[g])
    );
  end

  fan_reg_window #(.NF(NF), .NT(NT), .CW(CW)) u_win (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fan_result (fan_result),
    .temp_in    (temp_in),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .index_out  (index_q)
  );

endmodule

// File: rtl/fan_tach_monitor_chk.sv
module fan_tach_monitor_chk
  import fan_mon_pkg::*;
#(
  parameter int NF = NUM_FANS,
  parameter int NT = NUM_TEMPS,
  parameter int CW = CNT_W
) (
  input logic                 clk,
  input logic                 rst_ok,
  input logic                 tick_en,
  input logic [NT*BYTE_W-1:0] temp_in,
  input logic                 host_sel,
  input logic                 host_wr,
  input logic                 host_rd,
  input logic [BYTE_W-1:0]    host_rdata,
  input logic [BYTE_W-1:0]    index_q,
  input logic [NF-1:0]        tach_rise,
  input logic [NF-1:0][CW-1:0] fan_run,
  input logic [NF-1:0][CW-1:0] fan_result
);

  localparam logic [CW-1:0] FULL = '1;

  function automatic logic idx_mapped(input logic [BYTE_W-1:0] i);
    logic hit;
    hit = 1'b0;
    for (int t = 0; t < NT; t++) if (i == TEMP_IDX[t]) hit = 1'b1;
    if (i >= FAN_BASE_IDX && i < FAN_BASE_IDX + BYTE_W'(2 * NF)) hit = 1'b1;
    return hit;
  endfunction

  // R1: read data holds while no read strobe
  assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    !host_rd |=> $stable(host_rdata));

  // R2: temperature byte 0 appears at its index
  assert_temp0_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (host_rd && host_sel && index_q == TEMP_IDX[0]) |=> host_rdata == $past(temp_in[BYTE_W-1:0]));

  // R7: unmapped indices read zero
  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (host_rd && host_sel && !idx_mapped(index_q)) |=> host_rdata == '0);

  // R8: data-location writes leave the index alone
  assert_data_wr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    (host_wr && host_sel) |=> $stable(index_q));

  // R10: no tick and no edge freezes every count and result
  assert_no_tick_frozen_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (!tick_en && tach_rise == '0) |=> ($stable(fan_run) && $stable(fan_result)));

  logic [NF-1:0][BYTE_W-1:0] exp_hi_q;
  logic [NF-1:0]             have_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      exp_hi_q <= '0;
      have_q   <= '0;
    end else begin
      for (int k = 0; k < NF; k++) begin
        if (host_rd && host_sel && index_q == fan_lo_idx(k)) begin
          exp_hi_q[k] <= fan_result[k][CW-1:BYTE_W];
          have_q[k]   <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NF; g++) begin : g_chk
    // R3: an edge restarts the running count
    assert_edge_restart_R3: assert property (@(posedge clk) disable iff (!rst_ok)
      tach_rise[g] |=> fan_run[g] == '0);

    // R5: a saturated count with no edge stays saturated and marks the result
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_ok)
      (fan_run[g] == FULL && !tach_rise[g]) |=> (fan_run[g] == FULL && fan_result[g] == FULL));

    // R6: high-byte read returns the byte captured by the last low-byte read
    assert_hi_shadow_R6: assert property (@(posedge clk) disable iff (!rst_ok)
      (host_rd && host_sel && index_q == fan_hi_idx(g) && have_q[g]) |=> host_rdata == exp_hi_q[g]);
  end

endmodule

bind fan_tach_monitor fan_tach_monitor_chk #(.NF(NF), .NT(NT), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .tick_en    (tick_en),
  .temp_in    (temp_in),
  .host_sel   (host_sel),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .index_q    (index_q),
  .tach_rise  (tach_rise),
  .fan_run    (fan_run),
  .fan_result (fan_result)
);

// File: tb/fan_tach_monitor_test.sv
module fan_tach_monitor_test;

  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic [3:0]  tach_in;
  logic [31:0] temp_in;
  logic        host_sel;
  logic        host_wr;
  logic        host_rd;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;

  int checks;
  int fails;
  int cyc;
  int per [4];
  int ph  [4];
  int tick_div;
  int tick_ph;

  fan_tach_monitor uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .tach_in    (tach_in),
    .temp_in    (temp_in),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // stimulus generators: tach period per channel, tick every tick_div cycles
  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (per[k] == 0) begin
        ph[k] = 0;
        tach_in[k] = 1'b0;
      end else begin
        tach_in[k] = (ph[k] < per[k] / 2);
        ph[k] = (ph[k] + 1 >= per[k]) ? 0 : ph[k] + 1;
      end
    end
    if (tick_div == 0) begin
      tick_en = 1'b0;
      tick_ph = 0;
    end else begin
      tick_en = (tick_ph == 0);
      tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_index(input logic [7:0] idx);
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b1; host_wdata = idx;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] val);
    host_sel = sel; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    val = host_rdata;
  endtask

  task automatic read_reg(input logic [7:0] idx, output logic [7:0] val);
    set_index(idx);
    rd(1'b1, val);
  endtask

  task automatic read_fan(input int k, output int val);
    logic [7:0] lo, hi;
    read_reg(8'(8'h28 + 2 * k), lo);
    read_reg(8'(8'h29 + 2 * k), hi);
    val = {hi, lo};
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R9", "rdata after reset", host_rdata, 0);
    rd(1'b0, v);
    chk("R9", "index after reset", v, 0);
    read_reg(8'h29, v);
    chk("R9", "fan0 shadow after reset", v, 0);
    read_reg(8'h28, v);
    chk("R9", "fan0 low after reset", v, 0);
  endtask

  task automatic t_index_and_temps;
    logic [7:0] v;
    set_index(8'h3C);
    rd(1'b0, v);
    chk("R1", "index readback", v, 8'h3C);
    idle(3);
    chk("R1", "rdata held with no read", host_rdata, 8'h3C);
    read_reg(8'h25, v); chk("R2", "temp byte 0", v, 8'h11);
    read_reg(8'h26, v); chk("R2", "temp byte 1", v, 8'hA2);
    read_reg(8'h27, v); chk("R2", "temp byte 2", v, 8'h5F);
    read_reg(8'h80, v); chk("R2", "temp byte 3", v, 8'hE7);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    read_reg(8'h24, v); chk("R7", "index 0x24", v, 0);
    read_reg(8'h30, v); chk("R7", "index 0x30", v, 0);
    read_reg(8'h81, v); chk("R7", "index 0x81", v, 0);
    read_reg(8'hFF, v); chk("R7", "index 0xFF", v, 0);
  endtask

  task automatic t_write_ignored;
    logic [7:0] v;
    set_index(8'h26);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_wdata = 8'h5A;
    @(negedge clk);
    host_wr = 1'b0;
    rd(1'b0, v);
    chk("R8", "index after data write", v, 8'h26);
    rd(1'b1, v);
    chk("R8", "temp byte 1 after data write", v, 8'hA2);
  endtask

  task automatic t_counts;
    int v;
    per[0] = 300; per[1] = 1000; per[2] = 777;
    idle(3500);
    read_fan(0, v); chk("R3", "fan0 period 300", v, 300);
    read_fan(1, v); chk("R3", "fan1 period 1000", v, 1000);
    read_fan(2, v); chk("R3", "fan2 period 777", v, 777);
  endtask

  task automatic t_tick_gating;
    int v;
    tick_div = 4;
    idle(3500);
    read_fan(1, v); chk("R10", "fan1 with tick every 4th cycle", v, 250);
    tick_div = 0;
    idle(3500);
    read_fan(0, v); chk("R10", "fan0 with tick held low", v, 0);
    tick_div = 1;
    idle(3500);
  endtask

  task automatic t_tear;
    logic [7:0] v;
    per[0] = 16'h01F0;
    idle(2000);
    read_reg(8'h28, v); chk("R6", "fan0 low before change", v, 8'hF0);
    per[0] = 16'h0210;
    idle(2000);
    read_reg(8'h29, v); chk("R6", "fan0 high held from earlier low read", v, 8'h01);
    read_reg(8'h28, v); chk("R6", "fan0 fresh low", v, 8'h10);
    read_reg(8'h29, v); chk("R6", "fan0 fresh high", v, 8'h02);
  endtask

  task automatic t_stall_and_recover;
    int v;
    while (cyc < 90000) @(negedge clk);
    read_fan(3, v); chk("R5", "fan3 never pulsed saturates", v, 16'hFFFF);
    per[3] = 400;
    idle(1500);
    read_fan(3, v); chk("R4", "fan3 recovered period 400", v, 400);
  endtask

  initial begin
    checks = 0; fails = 0; cyc = 0;
    for (int k = 0; k < 4; k++) begin per[k] = 0; ph[k] = 0; end
    tick_div = 1; tick_ph = 0;
    tach_in = '0; tick_en = 1'b0;
    temp_in = {8'hE7, 8'h5F, 8'hA2, 8'h11};
    host_sel = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
    rst_n = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_index_and_temps;
    t_unmapped;
    t_write_ignored;
    t_counts;
    t_tick_gating;
    t_tear;
    t_stall_and_recover;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual cycle %0d expected completion before 190000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule